// File: doc/BRIEF.md
# Safety Status and Access-Error Monitor

This block gathers the fault reports of a random-number peripheral and presents them to software as sticky status bits. A clock-waveform fault, an internal sequencer fault, an illegal software read of the output-data register and a write to a protected register each set a flag of their own. The flags stay set until software reads the status register. An error-type field and a criticality-class field record the first illegal access seen since that read.

Whenever any of the four flags is set, an aggregated safety flag in the interrupt status is set as well. This flag drives the interrupt line through a mask bit. A read of the interrupt status clears the aggregated flag, but only once no status flag is still set. The fault detectors themselves sit outside the block: their outputs arrive as single-cycle pulses, and the bus read strobes arrive as single-cycle strobes.

Top module: `safety_mon`

## Requirements
- R1: After reset, all four status flags, the error type, the error class, the safety flag and the interrupt line are 0.
- R2: A clock-fault pulse or a sequencer-fault pulse sets its own flag at the next clock edge. The flag then stays set until the status register is read.
- R3: An output-data read while the generator is disabled sets the software-error flag, records type 1 (read while disabled) and records class 1 (error).
- R4: An output-data read while the generator is enabled and data-ready is low sets the software-error flag, records type 2 (read while not ready) and records class 0 (warning). A read while enabled and ready has no effect.
- R5: A write-protection violation pulse sets the write-protection flag, records type 3 (protected write) and records class 1.
- R6: A status-register read clears all four flags, and sets type to 0 and class to 0, at the next edge.
- R7: An event that arrives in the same cycle as a status read wins. Its flag stays set, and its type and class are recorded.
- R8: While the type field is non-zero and no status read occurs, later errors leave type and class unchanged.
- R9: The safety flag is 1 in every cycle in which any status flag is 1. An interrupt-status read clears it only when no flag is set after that edge.
- R10: The interrupt line is 1 exactly when the safety flag is 1 and the mask input is 1.
- R11: When illegal accesses arrive together, the recorded type follows this priority: read while disabled, then read while not ready, then protected write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkFaultPulse | input | 1 | Clock-waveform fault report |
| seqFaultPulse | input | 1 | Sequencer fault report |
| wpViolPulse | input | 1 | Write to a protected register |
| rdData | input | 1 | Output-data register read strobe |
| rdStatus | input | 1 | Status register read strobe |
| rdIntStatus | input | 1 | Interrupt status read strobe |
| genEnable | input | 1 | Generator enabled level |
| dataReady | input | 1 | Data-ready level |
| intMask | input | 1 | Mask bit for the safety interrupt |
| flagClkFault | output | 1 | Sticky clock-fault flag |
| flagSeqFault | output | 1 | Sticky sequencer-fault flag |
| flagSwErr | output | 1 | Sticky software access error flag |
| flagWpViol | output | 1 | Sticky write-protection violation flag |
| errType | output | 2 | Type of the first illegal access |
| errClass | output | 1 | Criticality of the recorded type |
| safetyFlag | output | 1 | Aggregated safety flag |
| irq | output | 1 | Masked safety interrupt |

## Verification
The hardest situation to reach from the ports is the collision case: a clearing read in the same cycle as a new event, while older errors are still pending. The bench first loads a flag and a type. It then drives a status read together with a not-ready data read, and checks that the new type replaces the old one while the older flag clears. In a separate sweep, the bench drives every combination of enable, ready, data read, protected write and mask from a clean state. It computes the expected type, class, flags and interrupt arithmetically for each case.

// File: rtl/safety_mon_pkg.sv
package safety_mon_pkg;

  localparam int NUM_FLAGS = 4;
  localparam int TYPE_W    = 2;

  // flag bit positions
  localparam int FLAG_CLK = 0;
  localparam int FLAG_SEQ = 1;
  localparam int FLAG_SW  = 2;
  localparam int FLAG_WP  = 3;

  typedef enum logic [TYPE_W-1:0] {
    ERR_NONE    = 2'd0,
    ERR_RD_DIS  = 2'd1,
    ERR_RD_NRDY = 2'd2,
    ERR_WP      = 2'd3
  } errType_e;

  typedef enum logic {
    CLS_WARN = 1'b0,
    CLS_ERR  = 1'b1
  } errClass_e;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setFlags;
    logic                 clrStatus;
    logic                 clrInt;
    logic                 loadErr;
    errType_e             newType;
    errClass_e            newClass;
  } monStrobes_t;

endpackage

// File: rtl/safety_mon_ctrl.sv
module safety_mon_ctrl
  import safety_mon_pkg::*;
(
  input  logic        clkFaultPulse,
  input  logic        seqFaultPulse,
  input  logic        wpViolPulse,
  input  logic        rdData,
  input  logic        rdStatus,
  input  logic        rdIntStatus,
  input  logic        genEnable,
  input  logic        dataReady,
  input  logic        errPending,
  output monStrobes_t stb
);

  logic rdWhileOff;
  logic rdNotReady;
  logic anyAccessErr;

  assign rdWhileOff   = rdData & ~genEnable;
  assign rdNotReady   = rdData & genEnable & ~dataReady;
  assign anyAccessErr = rdWhileOff | rdNotReady | wpViolPulse;

  always_comb begin
    stb = '0;
    stb.setFlags[FLAG_CLK] = clkFaultPulse;
    stb.setFlags[FLAG_SEQ] = seqFaultPulse;
    stb.setFlags[FLAG_SW]  = rdWhileOff | rdNotReady;
    stb.setFlags[FLAG_WP]  = wpViolPulse;
    stb.clrStatus = rdStatus;
    stb.clrInt    = rdIntStatus;
    // priority: disabled read, not-ready read, protected write
    if (rdWhileOff) begin
      stb.newType  = ERR_RD_DIS;
      stb.newClass = CLS_ERR;
    end else if (rdNotReady) begin
      stb.newType  = ERR_RD_NRDY;
      stb.newClass = CLS_WARN;
    end else if (wpViolPulse) begin
      stb.newType  = ERR_WP;
      stb.newClass = CLS_ERR;
    end else begin
      stb.newType  = ERR_NONE;
      stb.newClass = CLS_WARN;
    end
    // first error is held unless the field is being cleared this cycle
    stb.loadErr = anyAccessErr & (~errPending | rdStatus);
  end

endmodule

// File: rtl/safety_mon_dp.sv
module safety_mon_dp
  import safety_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  monStrobes_t          stb,
  output logic [NUM_FLAGS-1:0] flags,
  output errType_e             errTypeQ,
  output errClass_e            errClassQ,
  output logic                 safetyQ,
  output logic                 errPending
);

  logic [NUM_FLAGS-1:0] flagsNext;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic flagQ;
    // a set in the clearing cycle wins
    assign flagsNext[i] = (flagQ & ~stb.clrStatus) | stb.setFlags[i];
    always_ff @(posedge clk) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= flagsNext[i];
    end
    assign flags[i] = flagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errTypeQ  <= ERR_NONE;
      errClassQ <= CLS_WARN;
    end else if (stb.loadErr) begin
      errTypeQ  <= stb.newType;
      errClassQ <= stb.newClass;
    end else if (stb.clrStatus) begin
      errTypeQ  <= ERR_NONE;
      errClassQ <= CLS_WARN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) safetyQ <= 1'b0;
    else       safetyQ <= (|flagsNext) | (safetyQ & ~stb.clrInt);
  end

  assign errPending = (errTypeQ != ERR_NONE);

endmodule

// File: rtl/safety_mon.sv
module safety_mon
  import safety_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkFaultPulse,
  input  logic              seqFaultPulse,
  input  logic              wpViolPulse,
  input  logic              rdData,
  input  logic              rdStatus,
  input  logic              rdIntStatus,
  input  logic              genEnable,
  input  logic              dataReady,
  input  logic              intMask,
  output logic              flagClkFault,
  output logic              flagSeqFault,
  output logic              flagSwErr,
  output logic              flagWpViol,
  output logic [TYPE_W-1:0] errType,
  output logic              errClass,
  output logic              safetyFlag,
  output logic              irq
);

  monStrobes_t          stb;
  logic [NUM_FLAGS-1:0] flags;
  errType_e             errTypeQ;
  errClass_e            errClassQ;
  logic                 errPending;

  safety_mon_ctrl u_ctrl (
    .clkFaultPulse (clkFaultPulse),
    .seqFaultPulse (seqFaultPulse),
    .wpViolPulse   (wpViolPulse),
    .rdData        (rdData),
    .rdStatus      (rdStatus),
    .rdIntStatus   (rdIntStatus),
    .genEnable     (genEnable),
    .dataReady     (dataReady),
    .errPending    (errPending),
    .stb           (stb)
  );

  safety_mon_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .flags      (flags),
    .errTypeQ   (errTypeQ),
    .errClassQ  (errClassQ),
    .safetyQ    (safetyFlag),
    .errPending (errPending)
  );

  assign flagClkFault = flags[FLAG_CLK];
  assign flagSeqFault = flags[FLAG_SEQ];
  assign flagSwErr    = flags[FLAG_SW];
  assign flagWpViol   = flags[FLAG_WP];
  assign errType      = errTypeQ;
  assign errClass     = errClassQ;
  assign irq          = safetyFlag & intMask;

endmodule

// File: rtl/safety_mon_chk.sv
module safety_mon_chk (
  input logic       clk,
  input logic       rstN,
  input logic       clkFaultPulse,
  input logic       seqFaultPulse,
  input logic       wpViolPulse,
  input logic       rdData,
  input logic       rdStatus,
  input logic       genEnable,
  input logic       flagClkFault,
  input logic       flagSeqFault,
  input logic       flagSwErr,
  input logic       flagWpViol,
  input logic [1:0] errType,
  input logic       errClass,
  input logic       safetyFlag,
  input logic       irq
);

  p_clk_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    clkFaultPulse |=> flagClkFault);

  p_seq_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flagSeqFault && !rdStatus) |=> flagSeqFault);

  p_rd_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !genEnable) |=> (flagSwErr && errType != 2'd0));

  p_wp_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    wpViolPulse |=> flagWpViol);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !clkFaultPulse) |=> !flagClkFault);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errType != 2'd0 && !rdStatus) |=> ($stable(errType) && $stable(errClass)));

  p_safety_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagClkFault || flagSeqFault || flagSwErr || flagWpViol) |-> safetyFlag);

  p_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    !safetyFlag |-> !irq);

  p_class_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errType == 2'd2) |-> !errClass);

endmodule

bind safety_mon safety_mon_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .clkFaultPulse (clkFaultPulse),
  .seqFaultPulse (seqFaultPulse),
  .wpViolPulse   (wpViolPulse),
  .rdData        (rdData),
  .rdStatus      (rdStatus),
  .genEnable     (genEnable),
  .flagClkFault  (flagClkFault),
  .flagSeqFault  (flagSeqFault),
  .flagSwErr     (flagSwErr),
  .flagWpViol    (flagWpViol),
  .errType       (errType),
  .errClass      (errClass),
  .safetyFlag    (safetyFlag),
  .irq           (irq)
);

// File: tb/safety_mon_bench.sv
module safety_mon_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, clkFaultPulse, seqFaultPulse, wpViolPulse;
  logic rdData, rdStatus, rdIntStatus, genEnable, dataReady, intMask;
  logic flagClkFault, flagSeqFault, flagSwErr, flagWpViol;
  logic [1:0] errType;
  logic errClass, safetyFlag, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  safety_mon u_safety_mon (
    .clk(clk), .rstN(rstN),
    .clkFaultPulse(clkFaultPulse), .seqFaultPulse(seqFaultPulse),
    .wpViolPulse(wpViolPulse), .rdData(rdData), .rdStatus(rdStatus),
    .rdIntStatus(rdIntStatus), .genEnable(genEnable), .dataReady(dataReady),
    .intMask(intMask), .flagClkFault(flagClkFault), .flagSeqFault(flagSeqFault),
    .flagSwErr(flagSwErr), .flagWpViol(flagWpViol), .errType(errType),
    .errClass(errClass), .safetyFlag(safetyFlag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearPulses();
    clkFaultPulse = 0; seqFaultPulse = 0; wpViolPulse = 0;
    rdData = 0; rdStatus = 0; rdIntStatus = 0;
  endtask

  // inputs set at a negedge are captured at the following posedge;
  // this returns at the next negedge with the pulses removed
  task automatic step();
    @(negedge clk);
    clearPulses();
  endtask

  task automatic cleanUp();
    rdStatus = 1; step();
    rdIntStatus = 1; step();
  endtask

  initial begin
    rstN = 0; genEnable = 0; dataReady = 0; intMask = 0;
    clearPulses();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", {flagClkFault, flagSeqFault, flagSwErr, flagWpViol}, 0);
    chk("R1 type", errType, 0);
    chk("R1 class", errClass, 0);
    chk("R1 safety", safetyFlag, 0);
    intMask = 1;
    chk("R1 irq", irq, 0);
    rstN = 1;
    @(negedge clk);

    // R2 clock fault, held over idle cycles
    clkFaultPulse = 1; step();
    chk("R2 clk flag", flagClkFault, 1);
    step(); step();
    chk("R2 clk held", flagClkFault, 1);
    chk("R2 type untouched", errType, 0);
    chk("R9 safety", safetyFlag, 1);
    chk("R10 irq", irq, 1);
    // R9: int status read while flag still set keeps safety
    rdIntStatus = 1; step();
    chk("R9 safety kept", safetyFlag, 1);
    rdStatus = 1; step();
    chk("R6 clk cleared", flagClkFault, 0);
    chk("R9 safety after status read", safetyFlag, 1);
    rdIntStatus = 1; step();
    chk("R9 safety cleared", safetyFlag, 0);

    seqFaultPulse = 1; step();
    chk("R2 seq flag", flagSeqFault, 1);
    cleanUp();
    chk("R6 seq cleared", flagSeqFault, 0);

    // R8 first error held
    genEnable = 0; rdData = 1; step();
    wpViolPulse = 1; step();
    chk("R8 type held", errType, 1);
    chk("R8 class held", errClass, 1);
    chk("R5 wp flag", flagWpViol, 1);
    genEnable = 1; dataReady = 0; rdData = 1; step();
    chk("R8 type held again", errType, 1);

    // R7 event coinciding with status read
    clkFaultPulse = 1; step();
    rdStatus = 1; rdData = 1; genEnable = 1; dataReady = 0; step();
    chk("R7 sw flag kept", flagSwErr, 1);
    chk("R7 type replaced", errType, 2);
    chk("R7 class", errClass, 0);
    chk("R6 clk cleared on collision", flagClkFault, 0);
    chk("R6 wp cleared on collision", flagWpViol, 0);
    rdStatus = 1; step();
    chk("R6 type cleared", errType, 0);
    chk("R6 class cleared", errClass, 0);
    cleanUp();

    // sweep: enable, ready, data read, protected write, mask
    for (int v = 0; v < 32; v++) begin
      bit e, r, d, w, m, off, nr, sw;
      int expType, expClass;
      e = v[0]; r = v[1]; d = v[2]; w = v[3]; m = v[4];
      off = d & !e; nr = d & e & !r; sw = off | nr;
      expType = off ? 1 : nr ? 2 : w ? 3 : 0;
      expClass = (expType == 1 || expType == 3) ? 1 : 0;
      genEnable = e; dataReady = r; intMask = m;
      rdData = d; wpViolPulse = w;
      step();
      chk("R3/R4 sw flag", flagSwErr, sw);
      chk("R5 wp flag", flagWpViol, w);
      chk("R11 type", errType, expType);
      chk("R3/R5 class", errClass, expClass);
      chk("R9 safety", safetyFlag, sw | w);
      chk("R10 irq", irq, (sw | w) & m);
      cleanUp();
      chk("R6 sweep clear", {flagSwErr, flagWpViol, errType, errClass}, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule